// File: doc/BRIEF.md
# Lockable System Control Register Bank

This block is the control and status register file of a processor module. It sits on a simple word-addressed register bus with separate read and write strobes. It returns fixed identity and status words and holds oscillator settings that a software key must unlock before they can be written. It also holds a control word whose bits drive an indicator LED and the boot-memory remap, plus two flag words with separate set and clear aliases. A free-running reference counter and a small read-only memory descriptor window complete the map.

A write of the reset bit in the control word sends a one-cycle reset request to the system and leaves no trace in the register. The remap bit decides whether boot memory answers at address zero. A read returns its data one cycle after the read strobe, in a register that holds until the next read. An access to an offset with no register reads zero and raises a one-cycle error flag.

Top module: `sysctl_regbank`

## Requirements
- R1: Word offset 0 reads 0x411A3001, offset 1 reads 0 and offset 4 reads 0x00100000; these offsets ignore writes.
- R2: A write to the lock word (offset 5) keeps only bits 15:0. A read returns 0x0001A05F while the stored value is 0xA05F, and the stored value otherwise.
- R3: The oscillator word (offset 2) and the auxiliary oscillator word (offset 7) change on a write only while the lock word holds 0xA05F.
- R4: The control word (offset 3) stores only bits 0 and 2. A write with bit 3 set drives `reset_req_o` high for exactly the following cycle, and bit 3 always reads back as 0.
- R5: `boot_zero_o` is high while control bit 2 is clear and low while it is set. `led_o` follows control bit 0.
- R6: The first flag word reads at offset 12. A write to offset 12 ORs the data into it, and a write to offset 13 clears the bits that are set in the data. The second flag word works the same way at offsets 14 and 15.
- R7: Offset 10 reads a 32-bit count that starts at 0 at reset and advances at an average of REF_HZ per SYS_CLK_HZ clock cycles. With the default parameters it advances by exactly 24 in any 100 cycles and by exactly 12 in any 50.
- R8: Word offsets 0x40 to 0x5F read descriptor byte (offset − 0x40) in bits 7:0, with byte 0 = 0x80 and byte 31 = 0x20 for 128 MB. Word offsets 0x60 to 0x7F read 0.
- R9: After reset the oscillator word is 0x01000048, the auxiliary word 0x0007FEFF, the init word (offset 9) 0x00000112, and the SDRAM word (offset 8) 0x00011122 ORed with a size code. The size code is 0x10 for MEM_MB ≥ 256, 0x0C for ≥ 128, 0x08 for ≥ 64, 0x04 for ≥ 32, and 0 otherwise.
- R10: The SDRAM and init words accept and return full 32-bit writes.
- R11: Word offsets 32 to 35 read 0, ignore writes and raise no error.
- R12: A read or write to any other offset, including a write to a read-only offset, reads 0 and drives `bad_addr_o` high for the cycle after the access.
- R13: Read data appears on `rdata_o` in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 8 | Word offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| bad_addr_o | output | 1 | Access to an unimplemented offset, one cycle after the access |
| reset_req_o | output | 1 | One-cycle system reset request |
| boot_zero_o | output | 1 | Boot memory enabled at address zero |
| led_o | output | 1 | Indicator LED |

## Verification
The bench writes the oscillator word three times: while the key is absent, after the key has been written with junk in its upper half, and after the key has been replaced by another value. This separates the 16-bit masking of the key from the write guard. It writes the control word first with all ones and then with zero, which shows that only bits 0 and 2 are stored, that the reset pulse lasts a single cycle, and that both outputs follow. Set and clear writes with overlapping masks tell OR and AND-NOT apart on both flag words. Counter reads taken 100 and 50 cycles apart confirm the average rate of the fractional accumulator.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 8;

  localparam logic [AW-1:0] A_ID     = 8'd0;
  localparam logic [AW-1:0] A_PROC   = 8'd1;
  localparam logic [AW-1:0] A_OSC    = 8'd2;
  localparam logic [AW-1:0] A_CTRL   = 8'd3;
  localparam logic [AW-1:0] A_STAT   = 8'd4;
  localparam logic [AW-1:0] A_LOCK   = 8'd5;
  localparam logic [AW-1:0] A_AUX    = 8'd7;
  localparam logic [AW-1:0] A_SDRAM  = 8'd8;
  localparam logic [AW-1:0] A_INIT   = 8'd9;
  localparam logic [AW-1:0] A_REFCNT = 8'd10;
  localparam logic [AW-1:0] A_FLG_S  = 8'd12;
  localparam logic [AW-1:0] A_FLG_C  = 8'd13;
  localparam logic [AW-1:0] A_NVF_S  = 8'd14;
  localparam logic [AW-1:0] A_NVF_C  = 8'd15;

  localparam logic [DW-1:0] ID_VAL    = 32'h411A_3001;
  localparam logic [DW-1:0] STAT_VAL  = 32'h0010_0000;
  localparam logic [15:0]   UNLOCK    = 16'hA05F;
  localparam logic [DW-1:0] OSC_RST   = 32'h0100_0048;
  localparam logic [DW-1:0] AUX_RST   = 32'h0007_FEFF;
  localparam logic [DW-1:0] SDRAM_RST = 32'h0001_1122;
  localparam logic [DW-1:0] INIT_RST  = 32'h0000_0112;

  localparam int unsigned CTRL_LED = 0;
  localparam int unsigned CTRL_MAP = 2;
  localparam int unsigned CTRL_RST = 3;

  function automatic logic [DW-1:0] size_code(int mb);
    if (mb >= 256)     return 32'h10;
    else if (mb >= 128) return 32'h0C;
    else if (mb >= 64)  return 32'h08;
    else if (mb >= 32)  return 32'h04;
    else                return 32'h00;
  endfunction
endpackage

// File: rtl/sysctl_refcnt.sv
module sysctl_refcnt #(
  parameter int unsigned SYS_HZ = 100_000_000,
  parameter int unsigned REF_HZ = 24_000_000,
  parameter int unsigned CNT_W  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int unsigned ACC_W = $clog2(SYS_HZ + REF_HZ) + 1;

  generate
    if (REF_HZ >= SYS_HZ) begin : g_direct
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) cnt_o <= '0;
        else         cnt_o <= cnt_o + 1'b1;
    end else begin : g_frac
      localparam logic [ACC_W-1:0] STEP = ACC_W'(REF_HZ);
      localparam logic [ACC_W-1:0] WRAP = ACC_W'(SYS_HZ);
      logic [ACC_W-1:0] acc_q, acc_sum;
      assign acc_sum = acc_q + STEP;
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) begin
          acc_q <= '0;
          cnt_o <= '0;
        end else if (acc_sum >= WRAP) begin
          acc_q <= acc_sum - WRAP;
          cnt_o <= cnt_o + 1'b1;
        end else begin
          acc_q <= acc_sum;
        end
    end
  endgenerate
endmodule

// File: rtl/sysctl_desc_rom.sv
module sysctl_desc_rom #(
  parameter int unsigned MEM_MB = 128,
  parameter int unsigned DEPTH  = 32
) (
  input  logic [$clog2(DEPTH)-1:0] idx_i,
  output logic [7:0]               byte_o
);
  localparam logic [7:0] DENSITY = (MEM_MB >= 256) ? 8'd64 :
                                   (MEM_MB >= 128) ? 8'd32 :
                                   (MEM_MB >= 64)  ? 8'd16 :
                                   (MEM_MB >= 32)  ? 8'd4  : 8'd2;

  always_comb begin
    case (int'(idx_i))
      0:  byte_o = 8'h80;
      1:  byte_o = 8'h08;
      2:  byte_o = 8'h04;
      3:  byte_o = 8'h0B;
      4:  byte_o = 8'h09;
      5:  byte_o = 8'h01;
      6:  byte_o = 8'h40;
      8:  byte_o = 8'h02;
      9:  byte_o = 8'hA0;
      10: byte_o = 8'hA0;
      13: byte_o = 8'h08;
      15: byte_o = 8'h01;
      16: byte_o = 8'h0E;
      17: byte_o = 8'h04;
      18: byte_o = 8'h1C;
      19: byte_o = 8'h01;
      20: byte_o = 8'h02;
      21: byte_o = 8'h20;
      22: byte_o = 8'hC0;
      27: byte_o = 8'h30;
      28: byte_o = 8'h28;
      29: byte_o = 8'h30;
      30: byte_o = 8'h28;
      31: byte_o = DENSITY;
      default: byte_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter int unsigned MEM_MB     = 128,
  parameter int unsigned SYS_CLK_HZ = 100_000_000,
  parameter int unsigned REF_HZ     = 24_000_000,
  parameter int unsigned DESC_DEPTH = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          bad_addr_o,
  output logic          reset_req_o,
  output logic          boot_zero_o,
  output logic          led_o
);
  localparam int unsigned IDX_W = $clog2(DESC_DEPTH);

  logic [DW-1:0] osc_q, aux_q, sdram_q, init_q, flags_q, nvflags_q;
  logic [15:0]   lock_q;
  logic          led_q, map_q;
  logic [DW-1:0] refcnt;
  logic [7:0]    desc_byte;
  logic          unlocked, win_hit, volt_hit;
  logic [DW-1:0] rd_val;
  logic          rd_ok, wr_ok;

  sysctl_refcnt #(.SYS_HZ(SYS_CLK_HZ), .REF_HZ(REF_HZ), .CNT_W(DW)) i_refcnt (
    .clk_i, .rst_ni, .cnt_o(refcnt)
  );

  sysctl_desc_rom #(.MEM_MB(MEM_MB), .DEPTH(DESC_DEPTH)) i_rom (
    .idx_i(addr_i[IDX_W-1:0]), .byte_o(desc_byte)
  );

  assign unlocked = (lock_q == UNLOCK);
  assign win_hit  = (addr_i[7:6] == 2'b01);
  assign volt_hit = (addr_i[7:2] == 6'b001000);

  always_comb begin
    rd_val = '0;
    rd_ok  = 1'b1;
    if (win_hit) begin
      if (!addr_i[5]) rd_val = {24'd0, desc_byte};
    end else if (!volt_hit) begin
      case (addr_i)
        A_ID:     rd_val = ID_VAL;
        A_PROC:   rd_val = '0;
        A_OSC:    rd_val = osc_q;
        A_CTRL:   rd_val = DW'({map_q, 1'b0, led_q});
        A_STAT:   rd_val = STAT_VAL;
        A_LOCK:   rd_val = {15'd0, unlocked, lock_q};
        A_AUX:    rd_val = aux_q;
        A_SDRAM:  rd_val = sdram_q;
        A_INIT:   rd_val = init_q;
        A_REFCNT: rd_val = refcnt;
        A_FLG_S:  rd_val = flags_q;
        A_NVF_S:  rd_val = nvflags_q;
        default:  rd_ok  = 1'b0;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      A_OSC, A_CTRL, A_LOCK, A_AUX, A_SDRAM, A_INIT,
      A_FLG_S, A_FLG_C, A_NVF_S, A_NVF_C: wr_ok = 1'b1;
      default:                            wr_ok = volt_hit;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      osc_q       <= OSC_RST;
      aux_q       <= AUX_RST;
      sdram_q     <= SDRAM_RST | size_code(MEM_MB);
      init_q      <= INIT_RST;
      flags_q     <= '0;
      nvflags_q   <= '0;
      lock_q      <= '0;
      led_q       <= 1'b0;
      map_q       <= 1'b0;
      reset_req_o <= 1'b0;
      bad_addr_o  <= 1'b0;
      rdata_o     <= '0;
    end else begin
      reset_req_o <= wr_i && (addr_i == A_CTRL) && wdata_i[CTRL_RST];
      bad_addr_o  <= (wr_i && !wr_ok) || (rd_i && !rd_ok);
      if (rd_i) rdata_o <= rd_val;
      if (wr_i) begin
        case (addr_i)
          A_OSC:   if (unlocked) osc_q <= wdata_i;
          A_AUX:   if (unlocked) aux_q <= wdata_i;
          A_CTRL: begin
            led_q <= wdata_i[CTRL_LED];
            map_q <= wdata_i[CTRL_MAP];
          end
          A_LOCK:  lock_q    <= wdata_i[15:0];
          A_SDRAM: sdram_q   <= wdata_i;
          A_INIT:  init_q    <= wdata_i;
          A_FLG_S: flags_q   <= flags_q | wdata_i;
          A_FLG_C: flags_q   <= flags_q & ~wdata_i;
          A_NVF_S: nvflags_q <= nvflags_q | wdata_i;
          A_NVF_C: nvflags_q <= nvflags_q & ~wdata_i;
          default: ;
        endcase
      end
    end
  end

  assign boot_zero_o = ~map_q;
  assign led_o       = led_q;
endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk
  import sysctl_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_i,
  input logic          rd_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] rdata_o,
  input logic          reset_req_o,
  input logic          boot_zero_o,
  input logic [DW-1:0] osc_q,
  input logic [DW-1:0] aux_q,
  input logic [15:0]   lock_q,
  input logic [DW-1:0] flags_q
);
  // R4
  rst_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |-> $past(wr_i && (addr_i == A_CTRL) && wdata_i[CTRL_RST]));

  // R4
  rst_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reset_req_o && !(wr_i && (addr_i == A_CTRL))) |=> !reset_req_o);

  // R3
  osc_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q != UNLOCK) |=> ($stable(osc_q) && $stable(aux_q)));

  // R5
  remap_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(boot_zero_o) |-> $past(wr_i && (addr_i == A_CTRL)));

  // R6
  flag_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(flags_q) |-> $past(wr_i && ((addr_i == A_FLG_S) || (addr_i == A_FLG_C))));

  // R13
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rdata_o) |-> $past(rd_i));
endmodule

bind sysctl_regbank sysctl_regbank_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .reset_req_o(reset_req_o),
  .boot_zero_o(boot_zero_o), .osc_q(osc_q), .aux_q(aux_q), .lock_q(lock_q),
  .flags_q(flags_q)
);

// File: tb/test_sysctl_regbank.sv
module test_sysctl_regbank;
  localparam time CLK_PERIOD = 10ns;
  localparam int  MEM_MB     = 128;

  logic        clk_i = 1'b0, rst_ni = 1'b0, wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic        bad_addr_o, reset_req_o, boot_zero_o, led_o;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  bit fired_q = 1'b0;
  logic [31:0] q_val[$];
  bit          q_bad[$];
  bit          q_skip[$];
  string       q_tag[$];
  logic [31:0] cnt_a, cnt_b;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sysctl_regbank #(.MEM_MB(MEM_MB)) i_sysctl_regbank (
    .clk_i, .rst_ni, .wr_i, .rd_i, .addr_i, .wdata_i, .rdata_o,
    .bad_addr_o, .reset_req_o, .boot_zero_o, .led_o
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit wr_legal(input logic [7:0] a);
    return (a inside {8'd2, 8'd3, 8'd5, 8'd7, 8'd8, 8'd9, 8'd12, 8'd13,
                      8'd14, 8'd15, 8'd32, 8'd33, 8'd34, 8'd35});
  endfunction

  // monitor: the read issued at edge P is compared at the falling edge after P
  always @(posedge clk_i) fired_q <= rd_i;
  always @(negedge clk_i) begin
    if (fired_q && q_val.size() > 0) begin
      logic [31:0] ev;
      bit eb, sk;
      string tg;
      ev = q_val.pop_front(); eb = q_bad.pop_front();
      sk = q_skip.pop_front(); tg = q_tag.pop_front();
      if (!sk) begin
        chk(rdata_o === ev, tg, rdata_o, ev);
        chk(bad_addr_o === eb, {tg, " bad_addr"}, {31'd0, bad_addr_o}, {31'd0, eb});
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk_i); #1;
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1;
    wr_i = 1'b0;
    // R12 write-side error flag; R4 request pulse
    chk(bad_addr_o === !wr_legal(a), "R12 write error flag", {31'd0, bad_addr_o},
        {31'd0, !wr_legal(a)});
    chk(reset_req_o === (a == 8'd3 && d[3]), "R4 reset request", {31'd0, reset_req_o},
        {31'd0, (a == 8'd3 && d[3])});
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] ev, input bit eb, input string tg);
    q_val.push_back(ev); q_bad.push_back(eb); q_skip.push_back(1'b0); q_tag.push_back(tg);
    @(posedge clk_i); #1;
    rd_i = 1'b1; addr_i = a;
    @(posedge clk_i); #1;
    rd_i = 1'b0;
  endtask

  task automatic rd_raw(input logic [7:0] a, output logic [31:0] v);
    q_val.push_back('0); q_bad.push_back(1'b0); q_skip.push_back(1'b1); q_tag.push_back("");
    @(posedge clk_i); #1;
    rd_i = 1'b1; addr_i = a;
    @(posedge clk_i); #1;
    rd_i = 1'b0;
    v = rdata_o;
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R7 counter starts near zero
    rd_raw(8'd10, cnt_a);
    chk(cnt_a < 32'd3, "R7 count after reset", cnt_a, 32'd2);

    // R9 reset values, R5 outputs after reset
    chk(boot_zero_o === 1'b1 && led_o === 1'b0, "R5 reset outputs",
        {30'd0, boot_zero_o, led_o}, 32'h2);
    rd(8'd2, 32'h0100_0048, 0, "R9 osc reset");
    rd(8'd7, 32'h0007_FEFF, 0, "R9 aux reset");
    rd(8'd8, 32'h0001_112E, 0, "R9 sdram reset with size code");
    rd(8'd9, 32'h0000_0112, 0, "R9 init reset");
    rd(8'd3, 32'h0, 0, "R4 ctrl reset");
    rd(8'd5, 32'h0, 0, "R2 lock reset");

    // R1 constants, write ignored
    wr(8'd0, 32'hFFFF_FFFF);
    rd(8'd0, 32'h411A_3001, 0, "R1 id");
    rd(8'd1, 32'h0, 0, "R1 proc");
    rd(8'd4, 32'h0010_0000, 0, "R1 status");

    // R3 locked writes ignored
    wr(8'd2, 32'hDEAD_BEEF);
    wr(8'd7, 32'hCAFE_F00D);
    rd(8'd2, 32'h0100_0048, 0, "R3 osc locked");
    rd(8'd7, 32'h0007_FEFF, 0, "R3 aux locked");
    // R2 key with junk upper half
    wr(8'd5, 32'hFFFF_A05F);
    rd(8'd5, 32'h0001_A05F, 0, "R2 unlocked readback");
    wr(8'd2, 32'h1234_5678);
    wr(8'd7, 32'h8765_4321);
    rd(8'd2, 32'h1234_5678, 0, "R3 osc unlocked");
    rd(8'd7, 32'h8765_4321, 0, "R3 aux unlocked");
    wr(8'd5, 32'h0001_2345);
    rd(8'd5, 32'h0000_2345, 0, "R2 low half kept");
    wr(8'd2, 32'h0);
    rd(8'd2, 32'h1234_5678, 0, "R3 osc relocked");

    // R4 / R5 control
    wr(8'd3, 32'hFFFF_FFFF);
    chk(boot_zero_o === 1'b0 && led_o === 1'b1, "R5 remap set",
        {30'd0, boot_zero_o, led_o}, 32'h1);
    @(posedge clk_i); #1;
    chk(reset_req_o === 1'b0, "R4 pulse one cycle", {31'd0, reset_req_o}, 32'h0);
    rd(8'd3, 32'h5, 0, "R4 ctrl bits");
    wr(8'd3, 32'h0);
    chk(boot_zero_o === 1'b1 && led_o === 1'b0, "R5 remap clear",
        {30'd0, boot_zero_o, led_o}, 32'h2);
    wr(8'd3, 32'h4);
    rd(8'd3, 32'h4, 0, "R4 remap only");

    // R6 flags
    wr(8'd12, 32'h0000_00F0);
    wr(8'd12, 32'h0000_0F00);
    wr(8'd13, 32'h0000_0330);
    rd(8'd12, 32'h0000_0CC0, 0, "R6 flags set/clear");
    wr(8'd14, 32'hA000_0005);
    wr(8'd15, 32'h8000_0001);
    wr(8'd14, 32'h0000_0010);
    rd(8'd14, 32'h2000_0014, 0, "R6 nv flags set/clear");
    rd(8'd12, 32'h0000_0CC0, 0, "R6 flags untouched by nv writes");

    // R10 full-width
    wr(8'd8, 32'hA5A5_5A5A);
    wr(8'd9, 32'h0F0F_F0F0);
    rd(8'd8, 32'hA5A5_5A5A, 0, "R10 sdram");
    rd(8'd9, 32'h0F0F_F0F0, 0, "R10 init");

    // R8 window
    rd(8'h40, 32'h80, 0, "R8 descriptor byte 0");
    rd(8'h49, 32'hA0, 0, "R8 descriptor byte 9");
    rd(8'h5F, 32'h20, 0, "R8 descriptor size byte");
    rd(8'h60, 32'h0, 0, "R8 upper window zero");
    rd(8'h7F, 32'h0, 0, "R8 upper window end zero");

    // R11 voltage
    wr(8'd33, 32'hFFFF_FFFF);
    rd(8'd33, 32'h0, 0, "R11 voltage reads zero");
    rd(8'd35, 32'h0, 0, "R11 voltage last");

    // R12 unimplemented
    rd(8'd6, 32'h0, 1, "R12 read hole");
    rd(8'd13, 32'h0, 1, "R12 read of clear alias");
    rd(8'd36, 32'h0, 1, "R12 read past voltage");
    wr(8'd6, 32'h1);
    wr(8'd10, 32'h1);

    // R13 hold between reads
    rd(8'd0, 32'h411A_3001, 0, "R13 read");
    repeat (3) @(posedge clk_i);
    #1 chk(rdata_o === 32'h411A_3001, "R13 hold", rdata_o, 32'h411A_3001);

    // R7 rate: reads 100 and 50 edges apart
    rd_raw(8'd10, cnt_a);
    repeat (98) @(posedge clk_i);
    rd_raw(8'd10, cnt_b);
    chk(cnt_b - cnt_a == 32'd24, "R7 count over 100 cycles", cnt_b - cnt_a, 32'd24);
    rd_raw(8'd10, cnt_a);
    repeat (48) @(posedge clk_i);
    rd_raw(8'd10, cnt_b);
    chk(cnt_b - cnt_a == 32'd12, "R7 count over 50 cycles", cnt_b - cnt_a, 32'd12);

    repeat (2) @(posedge clk_i);
    done = 1'b1;
    report();
    $finish;
  end
endmodule